// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level tree of page tables kept in ordinary memory. A requester hands it an address and a read/write flag. The walker reads one entry from the top-level table, then one entry from the leaf table that the first entry points to. It checks the valid and permission bits and returns either the physical address or a coded fault. The only per-process state is a root pointer that names the page holding the top-level table, so a context switch only has to rewrite that one register.

Both lookups use one read port of arbitrary latency, and only one read is in flight at a time. The controller is a six-state machine. IDLE accepts a request and moves to FETCH1. FETCH1 issues the top-level read and moves to WAIT1. WAIT1 waits for the response. It moves to FETCH2 when the entry is valid and to REPLY when it is not. FETCH2 issues the leaf read and moves to WAIT2. WAIT2 waits for the response and moves to REPLY. REPLY reports the result for one cycle and returns to IDLE.

Top module: `pt_walker`

## Requirements
- R1: The top-level entry is read at byte address {root page, VA[31:22], 2'b00}. The root page is the value last written through `root_wdata[31:12]`.
- R2: After a valid top-level entry, the leaf entry is read at byte address {top entry[31:12], VA[21:12], 2'b00}.
- R3: On success, `paddr` = {leaf entry[31:12], VA[11:0]}, with the page offset passed through unchanged.
- R4: If bit 0 of the top-level entry is 0, the walk ends with `fault_code` = 1 and no leaf read is issued.
- R5: If bit 0 of the leaf entry is 0, the walk ends with `fault_code` = 2.
- R6: For a valid leaf, a read needs leaf bit 1 and a write needs leaf bit 2. Without that bit the walk ends with `fault_code` = 3.
- R7: Entry bits 11:3, and bits 2:1 of a top-level entry, have no effect on the result. A successful walk reports `fault_code` = 0.
- R8: `mem_req` is a one-cycle pulse with `mem_addr` word aligned. No new read is issued until `mem_rsp_valid` has answered the previous one, and the response may arrive any number of cycles later.
- R9: `req_ready` is high only in IDLE. `done` is a one-cycle pulse, and `fault` is high only together with `done`. `paddr` is 0 when a fault is reported, and the walker is ready again in the cycle after `done`.
- R10: A root write takes effect only when `req_ready` is high. A write made during a walk is discarded.
- R11: After reset the walker is idle: `req_ready` is 1, and `done`, `fault` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_we | input | 1 | Root pointer write strobe |
| root_wdata | input | 32 | New root table address; bits 31:12 are kept |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| done | output | 1 | Result valid, one cycle |
| fault | output | 1 | Walk failed, valid with done |
| fault_code | output | 2 | 0 none, 1 top entry invalid, 2 leaf invalid, 3 permission denied |
| paddr | output | 32 | Physical address, valid with done |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |

## Verification
The assertions assume that memory gives exactly one `mem_rsp_valid` pulse for each `mem_req`, at least one cycle after the request, and never without a pending read. They also assume that `req_valid` is judged only together with `req_ready`. The bench's memory model holds a single pending read with a latency from zero to three extra cycles. It computes entry contents arithmetically from the address, and it raises requests only while the walker is idle. A root write during a walk is the one deliberate out-of-phase stimulus, and R10 covers it.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        WS_IDLE   = 3'd0,
        WS_FETCH1 = 3'd1,
        WS_WAIT1  = 3'd2,
        WS_FETCH2 = 3'd3,
        WS_WAIT2  = 3'd4,
        WS_REPLY  = 3'd5
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE         = 2'd0,
        FLT_TOP_ABSENT   = 2'd1,
        FLT_LEAF_INVALID = 2'd2,
        FLT_DENIED       = 2'd3
    } fault_t;

    localparam int BIT_VALID = 0;
    localparam int BIT_READ  = 1;
    localparam int BIT_WRITE = 2;

endpackage

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
    import pt_walker_pkg::*;
#(
    parameter int ENT_W = 32,
    parameter int OFF_W = 12
) (
    input  logic [ENT_W-1:0]       entry,
    output logic [ENT_W-OFF_W-1:0] ppn,
    output logic                   ok,
    output logic                   can_read,
    output logic                   can_write
);
    logic unused_attr;

    assign ppn         = entry[ENT_W-1:OFF_W];
    assign ok          = entry[BIT_VALID];
    assign can_read    = entry[BIT_READ];
    assign can_write   = entry[BIT_WRITE];
    assign unused_attr = ^entry[OFF_W-1:BIT_WRITE+1];
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import pt_walker_pkg::*;
(
    input  logic   leaf_ok,
    input  logic   leaf_read,
    input  logic   leaf_write,
    input  logic   is_write,
    output fault_t verdict
);
    always_comb begin
        if (!leaf_ok)
            verdict = FLT_LEAF_INVALID;
        else if (is_write ? !leaf_write : !leaf_read)
            verdict = FLT_DENIED;
        else
            verdict = FLT_NONE;
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            root_we,
    input  logic [PA_W-1:0] root_wdata,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_write,
    output logic            done,
    output logic            fault,
    output logic [1:0]      fault_code,
    output logic [PA_W-1:0] paddr,
    output logic            mem_req,
    output logic [PA_W-1:0] mem_addr,
    input  logic            mem_rsp_valid,
    input  logic [PA_W-1:0] mem_rsp_data
);
    localparam int PPN_W   = PA_W - OFF_W;
    localparam int SLOT_SH = OFF_W - IDX_W;

    walk_state_t st_q, st_d;

    logic [IDX_W-1:0] idx_top_q, idx_leaf_q;
    logic [OFF_W-1:0] off_q;
    logic             wr_q;
    logic [PPN_W-1:0] root_q, tbl_q;
    logic [PA_W-1:0]  paddr_q;
    fault_t           code_q;

    logic [PPN_W-1:0] ent_ppn;
    logic             ent_ok, ent_rd, ent_wr;
    fault_t           leaf_verdict;
    logic             unused_low;

    assign unused_low = ^root_wdata[OFF_W-1:0];

    ptw_entry_decode #(.ENT_W(PA_W), .OFF_W(OFF_W)) u_dec (
        .entry     (mem_rsp_data),
        .ppn       (ent_ppn),
        .ok        (ent_ok),
        .can_read  (ent_rd),
        .can_write (ent_wr)
    );

    ptw_perm_check u_perm (
        .leaf_ok    (ent_ok),
        .leaf_read  (ent_rd),
        .leaf_write (ent_wr),
        .is_write   (wr_q),
        .verdict    (leaf_verdict)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WS_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WS_IDLE:   if (req_valid) st_d = WS_FETCH1;
            WS_FETCH1: st_d = WS_WAIT1;
            WS_WAIT1:  if (mem_rsp_valid) st_d = ent_ok ? WS_FETCH2 : WS_REPLY;
            WS_FETCH2: st_d = WS_WAIT2;
            WS_WAIT2:  if (mem_rsp_valid) st_d = WS_REPLY;
            WS_REPLY:  st_d = WS_IDLE;
            default:   st_d = WS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        mem_addr  = '0;
        done      = 1'b0;
        unique case (st_q)
            WS_IDLE:   req_ready = 1'b1;
            WS_FETCH1: begin
                mem_req  = 1'b1;
                mem_addr = {root_q, idx_top_q, {SLOT_SH{1'b0}}};
            end
            WS_FETCH2: begin
                mem_req  = 1'b1;
                mem_addr = {tbl_q, idx_leaf_q, {SLOT_SH{1'b0}}};
            end
            WS_REPLY:  done = 1'b1;
            default:   ;
        endcase
    end

    assign fault      = done && (code_q != FLT_NONE);
    assign fault_code = code_q;
    assign paddr      = paddr_q;

    // walk data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            root_q     <= '0;
            tbl_q      <= '0;
            idx_top_q  <= '0;
            idx_leaf_q <= '0;
            off_q      <= '0;
            wr_q       <= 1'b0;
            paddr_q    <= '0;
            code_q     <= FLT_NONE;
        end else begin
            if (root_we && st_q == WS_IDLE)
                root_q <= root_wdata[PA_W-1:OFF_W];
            if (st_q == WS_IDLE && req_valid) begin
                idx_top_q  <= req_vaddr[VA_W-1 -: IDX_W];
                idx_leaf_q <= req_vaddr[OFF_W+IDX_W-1:OFF_W];
                off_q      <= req_vaddr[OFF_W-1:0];
                wr_q       <= req_write;
                code_q     <= FLT_NONE;
                paddr_q    <= '0;
            end
            if (st_q == WS_WAIT1 && mem_rsp_valid) begin
                if (ent_ok) tbl_q <= ent_ppn;
                else        code_q <= FLT_TOP_ABSENT;
            end
            if (st_q == WS_WAIT2 && mem_rsp_valid) begin
                code_q  <= leaf_verdict;
                paddr_q <= (leaf_verdict == FLT_NONE) ? {ent_ppn, off_q} : '0;
            end
        end
    end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic [VA_W-1:0]       req_vaddr,
    input logic                  done,
    input logic                  fault,
    input logic [1:0]            fault_code,
    input logic [PA_W-1:0]       paddr,
    input logic                  mem_req,
    input logic [PA_W-1:0]       mem_addr,
    input logic                  mem_rsp_valid,
    input logic [PA_W-OFF_W-1:0] root_q
);
    logic [1:0]       reads_q;
    logic             pend_q;
    logic [OFF_W-1:0] off_q;
    logic             unused_in;

    assign unused_in = ^{req_vaddr[VA_W-1:OFF_W], mem_addr[OFF_W-1:2]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reads_q <= '0;
            pend_q  <= 1'b0;
            off_q   <= '0;
        end else begin
            if (req_valid && req_ready) begin
                reads_q <= '0;
                off_q   <= req_vaddr[OFF_W-1:0];
            end else if (mem_req && reads_q != 2'd3) begin
                reads_q <= reads_q + 2'd1;
            end
            if (mem_req)            pend_q <= 1'b1;
            else if (mem_rsp_valid) pend_q <= 1'b0;
        end
    end

    // R1
    top_read_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && reads_q == 2'd0) |-> mem_addr[PA_W-1:OFF_W] == root_q);

    // R2
    two_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code != 2'd1) |-> reads_q == 2'd2);

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> paddr[OFF_W-1:0] == off_q);

    // R4
    top_single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code == 2'd1) |-> reads_q == 2'd1);

    // R8
    mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R8
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (!pend_q && mem_addr[1:0] == 2'b00));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && paddr == '0));

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    root_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(root_q));
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .done          (done),
    .fault         (fault),
    .fault_code    (fault_code),
    .paddr         (paddr),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .root_q        (root_q)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_we = 1'b0;
    logic [31:0] root_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        done, fault;
    logic [1:0]  fault_code;
    logic [31:0] paddr;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [19:0] ROOT_A = 20'h00040;
    localparam logic [19:0] ROOT_B = 20'h00077;

    always #10 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .done(done), .fault(fault), .fault_code(fault_code),
        .paddr(paddr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // memory contents, computed from the address
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [19:0] pg;
        logic [9:0]  ix;
        logic [19:0] ppn;
        pg = a[31:12];
        ix = a[11:2];
        if (pg == ROOT_A || pg == ROOT_B) begin
            ppn = 20'h00100 + 20'(ix) + ((pg == ROOT_B) ? 20'h00400 : 20'h0);
            return {ppn, 11'h5A6, ((ix % 4) != 3) ? 1'b1 : 1'b0};
        end
        ppn = 20'((pg * 3) + 20'(ix));
        return {ppn, 9'h15B, ix[1], ix[0] ^ pg[0], ((ix % 5) != 4) ? 1'b1 : 1'b0};
    endfunction

    // memory model: one pending read, latency lat+1 cycles
    int          lat = 0;
    int          nreq = 0;
    logic [31:0] a1, a2;
    initial begin
        logic [31:0] maddr;
        int cnt;
        bit mbusy;
        mbusy = 0;
        cnt = 0;
        maddr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mbusy) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(maddr);
                    mbusy = 0;
                end else cnt--;
            end else if (mem_req) begin
                nreq++;
                if (nreq == 1) a1 = mem_addr; else a2 = mem_addr;
                maddr = mem_addr;
                cnt   = lat;
                mbusy = 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_root(input logic [19:0] pg);
        @(negedge clk);
        root_we = 1'b1;
        root_wdata = {pg, 12'hABC};
        @(negedge clk);
        root_we = 1'b0;
    endtask

    logic [19:0] cur_root = ROOT_A;

    task automatic walk(input logic [31:0] va, input logic wr, input int latency, input bit poke);
        logic [31:0] l1a, e1, l2a, e2, exp_pa;
        logic [1:0]  exp_code;
        int exp_n;
        bit seen;
        string ctag;
        l1a = {cur_root, va[31:22], 2'b00};
        e1 = mem_word(l1a);
        l2a = {e1[31:12], va[21:12], 2'b00};
        e2 = mem_word(l2a);
        if (!e1[0]) begin exp_code = 2'd1; exp_n = 1; end
        else begin
            exp_n = 2;
            if (!e2[0]) exp_code = 2'd2;
            else if (wr ? !e2[2] : !e2[1]) exp_code = 2'd3;
            else exp_code = 2'd0;
        end
        exp_pa = (exp_code == 2'd0) ? {e2[31:12], va[11:0]} : 32'h0;
        ctag = (exp_code == 2'd1) ? "R4" : (exp_code == 2'd2) ? "R5" : (exp_code == 2'd3) ? "R6" : "R7";

        lat = latency;
        nreq = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 ready low while busy", {63'h0, req_ready}, 64'h0);
        if (poke) begin
            root_we = 1'b1;
            root_wdata = {ROOT_B, 12'h0};
        end
        seen = 0;
        for (int k = 0; k < 60; k++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
            root_we = 1'b0;
        end
        root_we = 1'b0;
        chk("R9 done reached", {63'h0, seen}, 64'h1);
        chk("R1 top-level read address", {32'h0, a1}, {32'h0, l1a});
        if (exp_n == 2) chk("R2 leaf read address", {32'h0, a2}, {32'h0, l2a});
        chk("R8 read count", 64'(nreq), 64'(exp_n));
        chk({ctag, " fault code"}, {62'h0, fault_code}, {62'h0, exp_code});
        chk("R9 fault flag", {63'h0, fault}, {63'h0, (exp_code != 2'd0)});
        chk("R3 physical address", {32'h0, paddr}, {32'h0, exp_pa});
        @(negedge clk);
        chk("R9 done pulse ends", {63'h0, done}, 64'h0);
        chk("R9 ready after done", {63'h0, req_ready}, 64'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 ready in reset", {63'h0, req_ready}, 64'h1);
        chk("R11 done in reset", {63'h0, done}, 64'h0);
        chk("R11 mem_req in reset", {63'h0, mem_req}, 64'h0);
        chk("R11 fault in reset", {63'h0, fault}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 ready after reset", {63'h0, req_ready}, 64'h1);
        set_root(ROOT_A);

        for (int i1 = 0; i1 < 9; i1++) begin
            for (int i2 = 0; i2 < 11; i2++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [9:0]  x1, x2;
                    logic [11:0] off;
                    x1 = (i1 == 8) ? 10'd1023 : 10'(i1);
                    x2 = (i2 == 10) ? 10'd1023 : 10'(i2);
                    off = 12'((i1 * 37 + i2 * 11 + w * 2047) & 12'hFFF);
                    walk({x1, x2, off}, w[0], (i1 + i2 + w) % 4, 0);
                end
            end
        end

        // R10: root write during a walk is discarded
        walk({10'd5, 10'd2, 12'h123}, 1'b0, 3, 1);
        walk({10'd6, 10'd1, 12'h456}, 1'b0, 1, 0);
        chk("R10 busy root write ignored", {44'h0, a1[31:12]}, {44'h0, ROOT_A});
        // R10: root write while idle takes effect
        set_root(ROOT_B);
        cur_root = ROOT_B;
        walk({10'd6, 10'd1, 12'h456}, 1'b1, 0, 0);
        chk("R10 idle root write used", {44'h0, a1[31:12]}, {44'h0, ROOT_B});

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule